// File: doc/BRIEF.md
# Branch Hazard Controller

This block is the front-end control for conditional branches in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). The branch condition and target are resolved in the decode stage by hardware outside the block. The controller reads the decoded instruction's valid bit, its is-branch flag, the resolved outcome and the target. It owns the fetch program counter. Each cycle it chooses the next fetch address, says whether the fetch address is being held, and says whether the instruction now being fetched must be squashed into a bubble as it enters the fetch/decode register.

Three branch policies are available. The policy is captured while reset is asserted and does not change until the next reset.

- **Stall:** every branch inserts one bubble.
- **Predict-not-taken:** fetch continues sequentially. Only a taken branch costs a bubble.
- **Delayed branch:** the instruction after the branch always executes. The redirect lands after it, and no bubble is inserted.

After each resolved branch, a one-cycle report gives the number of cycles that branch occupied in the decode slot, counting the bubble if one was inserted.

The control core is a three-state machine:

- `ST_RUN` is the normal state.
- `ST_BUBBLE` is the cycle after a squash, when decode holds a bubble.
- `ST_SLOT` is the cycle after a delayed branch, when decode holds the delay-slot instruction.

Its transitions are:

- `ST_RUN` to `ST_BUBBLE` on any squash.
- `ST_RUN` to `ST_SLOT` on a branch under the delayed policy.
- `ST_BUBBLE` to `ST_RUN` and `ST_SLOT` to `ST_RUN` unconditionally.
- `ST_RUN` to `ST_RUN` otherwise.

Branch flags are acted on only in `ST_RUN`.

Top module: `bhc_ctrl`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals `RESET_PC`, and `ifid_flush`, `fetch_hold` and `cost_valid` are 0.
- R2: When no valid branch is acted on in decode, `fetch_pc` advances by `INC` on the next clock, with no flush and no hold.
- R3: Under the stall policy (`policy_sel` 2'b00, or the reserved code 2'b11, which behaves the same), every valid branch in decode raises `ifid_flush`. A taken branch loads `id_target` into `fetch_pc`. A not-taken branch raises `fetch_hold` and keeps `fetch_pc` unchanged, so the next sequential instruction is fetched again.
- R4: Under predict-not-taken (`policy_sel` 2'b01), a not-taken branch raises neither flush nor hold, and `fetch_pc` advances by `INC`.
- R5: Under predict-not-taken, a taken branch raises `ifid_flush` and loads `id_target` into `fetch_pc`. The cycle after any flush never flushes.
- R6: Under delayed branch (`policy_sel` 2'b10), no flush or hold is ever raised. A taken branch loads `id_target` on the clock that follows the fetch of the delay-slot instruction.
- R7: Under delayed branch, a branch flag on the instruction in the delay slot is ignored, and fetch stays sequential.
- R8: A branch flag with `id_valid` low has no effect.
- R9: `policy_sel` is sampled only while reset is asserted. Changes after reset release have no effect until the next reset.
- R10: On the clock after a branch is acted on, `cost_valid` pulses for one cycle. `cost_cycles` carries 2 when a bubble was inserted and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asynchronous for state; the policy is sampled on clocks while it is low |
| policy_sel | input | 2 | Branch policy: 00 stall, 01 predict-not-taken, 10 delayed, 11 treated as stall |
| id_valid | input | 1 | The decode-stage instruction is valid, not a bubble |
| id_is_branch | input | 1 | The decode-stage instruction is a conditional branch |
| id_taken | input | 1 | Resolved branch outcome |
| id_target | input | AW | Resolved branch target |
| fetch_pc | output | AW | Address fetched this cycle |
| npc_sel | output | 2 | Next-PC choice: 0 sequential, 1 hold, 2 target |
| fetch_hold | output | 1 | The fetch address is held this cycle |
| ifid_flush | output | 1 | Clear the valid bit of the instruction entering the fetch/decode register |
| cost_valid | output | 1 | One-cycle pulse reporting a resolved branch |
| cost_cycles | output | CW | Decode-slot cycles spent by the reported branch |

## Verification
The bench builds the block with a 16-bit address, `RESET_PC` 0 and `INC` 4. With these values a short looping program reaches every case within a few dozen cycles: a taken branch, a not-taken branch, two branches back to back, and a branch sitting in a delay slot or in a squashed slot. Each policy, including the reserved code, runs from its own reset. One run switches `policy_sel` after reset release, which shows the latched policy is the one that governs.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        POL_STALL = 2'b00,
        POL_PNT   = 2'b01,
        POL_DELAY = 2'b10,
        POL_RSVD  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'b00,
        NPC_HOLD   = 2'b01,
        NPC_TARGET = 2'b10
    } npc_sel_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_BUBBLE = 2'b01,
        ST_SLOT   = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  policy_e  policy_sel,
    input  logic     br_valid,
    input  logic     br_taken,
    output npc_sel_e npc_sel,
    output logic     flush,
    output logic     hold,
    output logic     resolved
);

    ctl_state_e state_q;
    ctl_state_e state_nx;
    policy_e    pol_q;
    logic       br_act;

    // Policy captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= (policy_sel == POL_RSVD) ? POL_STALL : policy_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    assign br_act = br_valid && (state_q == ST_RUN);

    always_comb begin
        state_nx = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (br_act) begin
                    unique case (pol_q)
                        POL_PNT:   state_nx = br_taken ? ST_BUBBLE : ST_RUN;
                        POL_DELAY: state_nx = ST_SLOT;
                        default:   state_nx = ST_BUBBLE;
                    endcase
                end
            end
            ST_BUBBLE: state_nx = ST_RUN;
            ST_SLOT:   state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        npc_sel  = NPC_SEQ;
        flush    = 1'b0;
        resolved = br_act;
        if (br_act) begin
            unique case (pol_q)
                POL_PNT: begin
                    if (br_taken) begin
                        npc_sel = NPC_TARGET;
                        flush   = 1'b1;
                    end
                end
                POL_DELAY: begin
                    npc_sel = br_taken ? NPC_TARGET : NPC_SEQ;
                end
                default: begin
                    npc_sel = br_taken ? NPC_TARGET : NPC_HOLD;
                    flush   = 1'b1;
                end
            endcase
        end
        hold = (npc_sel == NPC_HOLD);
    end

    // R5: a squash is always followed by a bubble cycle that cannot squash
    a_r5_no_double_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R6: the delayed policy never squashes or holds
    a_r6_delay_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q == POL_DELAY) |-> (!flush && !hold));

    // R7: the delay slot always proceeds sequentially
    a_r7_slot_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT) |-> (npc_sel == NPC_SEQ && !flush));

    // R9: the latched policy does not move after reset release
    a_r9_policy_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pol_q));

endmodule

// File: rtl/bhc_fetch_pc.sv
module bhc_fetch_pc
    import bhc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter int          INC      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  npc_sel_e      sel,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] STEP = AW'(INC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else begin
            unique case (sel)
                NPC_HOLD:   pc <= pc;
                NPC_TARGET: pc <= target;
                default:    pc <= pc + STEP;
            endcase
        end
    end

    // R3: a hold request leaves the fetch address in place
    a_r3_hold_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == NPC_HOLD) |=> $stable(pc));

endmodule

// File: rtl/bhc_cost.sv
module bhc_cost #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resolved,
    input  logic          bubble,
    output logic          cost_valid,
    output logic [CW-1:0] cost_cycles
);

    localparam logic [CW-1:0] BASE_COST   = CW'(1);
    localparam logic [CW-1:0] BUBBLE_COST = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cost_valid  <= 1'b0;
            cost_cycles <= '0;
        end else begin
            cost_valid <= resolved;
            if (resolved) begin
                cost_cycles <= bubble ? (BASE_COST + BUBBLE_COST) : BASE_COST;
            end
        end
    end

    // R10: a reported cost is one or two cycles
    a_r10_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> (cost_cycles == CW'(1) || cost_cycles == CW'(2)));

endmodule

// File: rtl/bhc_ctrl.sv
module bhc_ctrl
    import bhc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter int            INC      = 4,
    parameter int            CW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    policy_sel,
    input  logic          id_valid,
    input  logic          id_is_branch,
    input  logic          id_taken,
    input  logic [AW-1:0] id_target,
    output logic [AW-1:0] fetch_pc,
    output logic [1:0]    npc_sel,
    output logic          fetch_hold,
    output logic          ifid_flush,
    output logic          cost_valid,
    output logic [CW-1:0] cost_cycles
);

    npc_sel_e sel_w;
    logic     resolved_w;

    bhc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_sel (policy_e'(policy_sel)),
        .br_valid   (id_valid && id_is_branch),
        .br_taken   (id_taken),
        .npc_sel    (sel_w),
        .flush      (ifid_flush),
        .hold       (fetch_hold),
        .resolved   (resolved_w)
    );

    bhc_fetch_pc #(
        .AW       (AW),
        .RESET_PC (RESET_PC),
        .INC      (INC)
    ) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_w),
        .target (id_target),
        .pc     (fetch_pc)
    );

    bhc_cost #(
        .CW (CW)
    ) u_cost (
        .clk         (clk),
        .rst_n       (rst_n),
        .resolved    (resolved_w),
        .bubble      (ifid_flush),
        .cost_valid  (cost_valid),
        .cost_cycles (cost_cycles)
    );

    assign npc_sel = sel_w;

    // R8: an invalid decode slot never triggers a squash
    a_r8_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!ifid_flush && !fetch_hold && sel_w == NPC_SEQ));

endmodule

// File: tb/bhc_ctrl_tb_top.sv
module bhc_ctrl_tb_top;

    localparam int AW = 16;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    policy_sel = 2'b00;
    logic          id_valid;
    logic          id_is_branch;
    logic          id_taken;
    logic [AW-1:0] id_target;
    logic [AW-1:0] fetch_pc;
    logic [1:0]    npc_sel;
    logic          fetch_hold;
    logic          ifid_flush;
    logic          cost_valid;
    logic [CW-1:0] cost_cycles;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bhc_ctrl #(
        .AW       (AW),
        .RESET_PC (16'h0000),
        .INC      (4),
        .CW       (CW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy_sel   (policy_sel),
        .id_valid     (id_valid),
        .id_is_branch (id_is_branch),
        .id_taken     (id_taken),
        .id_target    (id_target),
        .fetch_pc     (fetch_pc),
        .npc_sel      (npc_sel),
        .fetch_hold   (fetch_hold),
        .ifid_flush   (ifid_flush),
        .cost_valid   (cost_valid),
        .cost_cycles  (cost_cycles)
    );

    // Program: branches at 0x10 (T->0x40), 0x44 (NT), 0x48 (T->0x80), 0x84 (T->0x10)
    function automatic bit is_br(input logic [AW-1:0] a);
        return (a == 16'h10) || (a == 16'h44) || (a == 16'h48) || (a == 16'h84);
    endfunction

    function automatic bit br_tk(input logic [AW-1:0] a);
        return a != 16'h44;
    endfunction

    function automatic logic [AW-1:0] br_tgt(input logic [AW-1:0] a);
        case (a)
            16'h10:  return 16'h40;
            16'h48:  return 16'h80;
            16'h84:  return 16'h10;
            default: return 16'h00;
        endcase
    endfunction

    // Fetch/decode register outside the block
    logic [AW-1:0] ifid_pc;
    logic          ifid_v;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ifid_pc <= '0;
            ifid_v  <= 1'b0;
        end else begin
            ifid_pc <= fetch_pc;
            ifid_v  <= !ifid_flush;
        end
    end

    assign id_valid     = ifid_v;
    assign id_is_branch = is_br(ifid_pc);
    assign id_taken     = br_tk(ifid_pc);
    assign id_target    = br_tgt(ifid_pc);

    // Reference model state
    int            m_pol;
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_id_pc;
    bit            m_id_v;
    int            m_mode;   // 0 normal, 1 bubble in decode, 2 delay slot in decode
    bit            m_cv;
    int            m_cost;
    bit            r9_phase;

    task automatic check(input string tag, input bit ok, input string detail);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    task automatic step();
        bit br;
        bit tk;
        bit e_flush;
        bit e_hold;
        logic [AW-1:0] nx;
        int c;
        string tag;
        br = m_id_v && is_br(m_id_pc) && (m_mode == 0);
        tk = br_tk(m_id_pc);
        e_flush = 0;
        e_hold = 0;
        nx = m_pc + 16'd4;
        c = 0;
        tag = "R2";
        if (!m_id_v && is_br(m_id_pc)) tag = "R8";
        if (m_mode == 2 && m_id_v && is_br(m_id_pc)) tag = "R7";
        if (br) begin
            case (m_pol)
                1: begin
                    if (tk) begin
                        e_flush = 1; nx = br_tgt(m_id_pc); c = 2; tag = "R5";
                    end else begin
                        c = 1; tag = "R4";
                    end
                end
                2: begin
                    if (tk) nx = br_tgt(m_id_pc);
                    c = 1; tag = "R6";
                end
                default: begin
                    e_flush = 1;
                    if (tk) nx = br_tgt(m_id_pc);
                    else begin nx = m_pc; e_hold = 1; end
                    c = 2; tag = "R3";
                end
            endcase
        end
        if (r9_phase) tag = "R9";
        check(tag, fetch_pc == m_pc && ifid_flush == e_flush && fetch_hold == e_hold,
              $sformatf("pc/flush/hold actual %h/%0b/%0b expected %h/%0b/%0b",
                        fetch_pc, ifid_flush, fetch_hold, m_pc, e_flush, e_hold));
        check("R10", cost_valid == m_cv && (!m_cv || cost_cycles == CW'(m_cost)),
              $sformatf("cost valid/cycles actual %0b/%0d expected %0b/%0d",
                        cost_valid, cost_cycles, m_cv, m_cost));
        m_id_pc = m_pc;
        m_id_v  = !e_flush;
        m_pc    = nx;
        m_mode  = e_flush ? 1 : ((br && m_pol == 2) ? 2 : 0);
        m_cv    = br;
        m_cost  = c;
    endtask

    task automatic run_policy(input logic [1:0] pol, input int cycles, input bit switch_mid);
        @(negedge clk);
        rst_n = 1'b0;
        policy_sel = pol;
        repeat (3) begin
            @(negedge clk);
            check("R1", fetch_pc == 16'h0 && !ifid_flush && !fetch_hold && !cost_valid,
                  $sformatf("reset pc/flush/hold/cv actual %h/%0b/%0b/%0b expected 0000/0/0/0",
                            fetch_pc, ifid_flush, fetch_hold, cost_valid));
        end
        m_pol    = (pol == 2'b11) ? 0 : int'(pol);
        m_pc     = '0;
        m_id_pc  = '0;
        m_id_v   = 0;
        m_mode   = 0;
        m_cv     = 0;
        m_cost   = 0;
        r9_phase = switch_mid;
        rst_n = 1'b1;
        #1;
        step();
        if (switch_mid) policy_sel = 2'b00;
        for (int i = 1; i < cycles; i++) begin
            @(negedge clk);
            if (switch_mid && i == 10) policy_sel = 2'b10;
            step();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        run_policy(2'b00, 40, 0);   // R3 stall
        run_policy(2'b01, 40, 0);   // R4, R5 predict-not-taken
        run_policy(2'b10, 40, 0);   // R6, R7 delayed branch
        run_policy(2'b11, 24, 0);   // R3 reserved code behaves as stall
        run_policy(2'b01, 40, 1);   // R9 policy changes after reset ignored
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

endmodule